// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address with 4 KB pages. When a miss is handed over, it reads the root page table entry from memory and then reads the second-level entry. It returns either a refill entry for the translation buffer or a page fault. The root table holds 1024 four-byte entries and sits at an address given by a base input. The second-level table base is the frame number of the root entry with twelve zero bits appended.

Memory is reached through a word-read port. A request is a single-cycle pulse carrying a byte address. The response arrives any number of cycles later, marked by a one-cycle valid strobe. Only one walk is in progress at a time. A new miss is taken only while the walker reports ready.

Every entry uses one layout:

| Bits | Field |
|------|-------|
| 0 | valid flag |
| 3:1 | permission bits |
| 5 | referenced flag |
| 6 | modified flag |
| 31:12 | frame number |
| 4, 11:7 | spare |

Top module: `ptw_engine`

## Requirements
- R1: After a synchronous active-low reset, `miss_ready` is 1 and `rd_req_valid`, `refill_valid` and `fault_valid` are 0.
- R2: A miss is taken only on a cycle where `miss_valid` and `miss_ready` are both high. `miss_ready` is low from acceptance until the walk ends, and a `miss_valid` raised during a walk has no effect on that walk.
- R3: One cycle after acceptance, `rd_req_valid` pulses for exactly one cycle. In that cycle `rd_req_addr` equals the latched root base plus four times VPN bits [19:10], where the VPN is virtual address bits [31:12].
- R4: If the root entry returned has bit 0 clear, then one cycle after the response `fault_valid` pulses with `fault_at_leaf`=0, and no second read is issued.
- R5: If the root entry has bit 0 set, then one cycle after the response a one-cycle read is issued. Its address is {root entry bits [31:12], 12'h000} plus four times VPN bits [9:0].
- R6: If the second-level entry has bit 0 clear, then one cycle after its response `fault_valid` pulses with `fault_at_leaf`=1.
- R7: If the second-level entry has bit 0 set, then one cycle after its response `refill_valid` pulses for one cycle with these fields:
  - `walk_vpn` is the VPN.
  - `refill_ppn` is entry bits [31:12].
  - `refill_perm` is entry bits [3:1].
  - `refill_ref` is entry bit 5.
  - `refill_mod` is entry bit 6.
- R8: The walker waits any number of cycles for a response. `rd_resp_valid` has no effect outside the two waiting states.
- R9: `miss_ready` returns to 1 on the cycle after a refill or fault pulse.
- R10: `refill_valid` and `fault_valid` are never high together. `rd_req_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, miss can be taken |
| miss_vaddr | input | 32 | Faulting virtual address |
| root_base | input | 32 | Byte address of the root table, sampled on acceptance |
| rd_req_valid | output | 1 | One-cycle memory read request |
| rd_req_addr | output | 32 | Byte address of the entry to read |
| rd_resp_valid | input | 1 | Read data valid strobe |
| rd_resp_data | input | 32 | Entry read from memory |
| refill_valid | output | 1 | Translation ready for insertion |
| walk_vpn | output | 20 | VPN of the current walk |
| refill_ppn | output | 20 | Physical page number |
| refill_perm | output | 3 | Permission bits |
| refill_ref | output | 1 | Referenced flag |
| refill_mod | output | 1 | Modified flag |
| fault_valid | output | 1 | Page fault pulse |
| fault_at_leaf | output | 1 | 0: root entry invalid, 1: second-level entry invalid |

## Verification
Each result has a fixed due cycle:
- The root read is due one cycle after acceptance.
- The second read, or a root fault, is due one cycle after the root response.
- The refill or leaf fault is due one cycle after the second response.
- Ready returns one cycle after that.

The bench plays the memory itself, with response latencies from zero to several cycles, and counts clock edges from each stimulus. It samples every output on the falling edge of each cycle and compares it against the value its own model expects for that cycle, including the idle outputs during the wait cycles. A model of memory and entry decoding, built from integer arithmetic, supplies the expected addresses and fields.

// File: rtl/ptw_pkg.sv
// Shared widths, entry layout and walker states for the page table walker.
// Assumes a two-level split of the VPN into equal-width index fields.
package ptw_pkg;
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int IDX_W      = 10;
    localparam int PTE_BYTES  = 4;
    localparam int PERM_W     = 3;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int PPN_W      = VA_W - PAGE_SHIFT;
    localparam int PTE_W      = PTE_BYTES * 8;
    localparam int PTE_SHIFT  = $clog2(PTE_BYTES);
    localparam int SPARE_HI_W = PAGE_SHIFT - 7;

    typedef struct packed {
        logic [PPN_W-1:0]      frame;
        logic [SPARE_HI_W-1:0] spare_hi;
        logic                  modified;
        logic                  referenced;
        logic                  spare_lo;
        logic [PERM_W-1:0]     perm;
        logic                  valid;
    } pte_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ROOT_REQ, ST_ROOT_WAIT, ST_LEAF_REQ,
        ST_LEAF_WAIT, ST_REFILL, ST_FAULT
    } walk_state_t;
endpackage

// File: rtl/ptw_addr_gen.sv
// Forms the byte address of the next entry to read: table base plus the
// scaled index taken from the upper or lower VPN field.
// Assumes the caller holds base and VPN stable for the request cycle.
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic             at_leaf,
    input  logic [VA_W-1:0]  root_base,
    input  logic [VA_W-1:0]  table_base,
    input  logic [VPN_W-1:0] vpn,
    output logic [VA_W-1:0]  entry_addr
);
    localparam int PAD_W = VA_W - IDX_W - PTE_SHIFT;

    logic [IDX_W-1:0] index;
    logic [VA_W-1:0]  base;

    // Select which VPN field and which table base apply to this level.
    always_comb begin
        index = at_leaf ? vpn[IDX_W-1:0] : vpn[VPN_W-1:IDX_W];
        base  = at_leaf ? table_base : root_base;
    end

    // Scale the index by the entry size and add it to the base.
    always_comb begin
        entry_addr = base + {{PAD_W{1'b0}}, index, {PTE_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/ptw_pte_decode.sv
// Splits a raw memory word into the entry fields used by the walker.
// Assumes the fixed layout held in ptw_pkg::pte_t; spare bits are dropped.
module ptw_pte_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0]  raw,
    output logic              valid,
    output logic [PERM_W-1:0] perm,
    output logic              referenced,
    output logic              modified,
    output logic [PPN_W-1:0]  frame
);
    pte_t entry;
    logic unused_spare;

    // Overlay the layout and pull out each field.
    always_comb begin
        entry        = pte_t'(raw);
        valid        = entry.valid;
        perm         = entry.perm;
        referenced   = entry.referenced;
        modified     = entry.modified;
        frame        = entry.frame;
        unused_spare = ^{entry.spare_hi, entry.spare_lo};
    end
endmodule

// File: rtl/ptw_engine.sv
// Two-level page table walker. It takes one miss at a time, reads the root
// entry and then the second-level entry, and ends with a refill or a fault.
// Assumes memory returns exactly one response per request, after any delay.
module ptw_engine
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VA_W-1:0]   miss_vaddr,
    input  logic [VA_W-1:0]   root_base,
    output logic              rd_req_valid,
    output logic [VA_W-1:0]   rd_req_addr,
    input  logic              rd_resp_valid,
    input  logic [PTE_W-1:0]  rd_resp_data,
    output logic              refill_valid,
    output logic [VPN_W-1:0]  walk_vpn,
    output logic [PPN_W-1:0]  refill_ppn,
    output logic [PERM_W-1:0] refill_perm,
    output logic              refill_ref,
    output logic              refill_mod,
    output logic              fault_valid,
    output logic              fault_at_leaf
);
    walk_state_t       state_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [VA_W-1:0]   root_q;
    logic [VA_W-1:0]   table_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [PERM_W-1:0] perm_q;
    logic              ref_q;
    logic              mod_q;
    logic              leaf_fault_q;

    logic              resp_ok;
    logic [PERM_W-1:0] resp_perm;
    logic              resp_ref;
    logic              resp_mod;
    logic [PPN_W-1:0]  resp_frame;
    logic [VA_W-1:0]   next_addr;
    logic              unused_vaddr;

    ptw_pte_decode u_decode (
        .raw        (rd_resp_data),
        .valid      (resp_ok),
        .perm       (resp_perm),
        .referenced (resp_ref),
        .modified   (resp_mod),
        .frame      (resp_frame)
    );

    ptw_addr_gen u_addr (
        .at_leaf    (state_q == ST_LEAF_REQ),
        .root_base  (root_q),
        .table_base (table_q),
        .vpn        (vpn_q),
        .entry_addr (next_addr)
    );

    // Walk sequencing: accept, read root, read leaf, then report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            vpn_q        <= '0;
            root_q       <= '0;
            table_q      <= '0;
            ppn_q        <= '0;
            perm_q       <= '0;
            ref_q        <= 1'b0;
            mod_q        <= 1'b0;
            leaf_fault_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (miss_valid) begin
                    vpn_q   <= miss_vaddr[VA_W-1:PAGE_SHIFT];
                    root_q  <= root_base;
                    state_q <= ST_ROOT_REQ;
                end
                ST_ROOT_REQ: state_q <= ST_ROOT_WAIT;
                ST_ROOT_WAIT: if (rd_resp_valid) begin
                    if (resp_ok) begin
                        table_q <= {resp_frame, {PAGE_SHIFT{1'b0}}};
                        state_q <= ST_LEAF_REQ;
                    end else begin
                        leaf_fault_q <= 1'b0;
                        state_q      <= ST_FAULT;
                    end
                end
                ST_LEAF_REQ: state_q <= ST_LEAF_WAIT;
                ST_LEAF_WAIT: if (rd_resp_valid) begin
                    if (resp_ok) begin
                        ppn_q   <= resp_frame;
                        perm_q  <= resp_perm;
                        ref_q   <= resp_ref;
                        mod_q   <= resp_mod;
                        state_q <= ST_REFILL;
                    end else begin
                        leaf_fault_q <= 1'b1;
                        state_q      <= ST_FAULT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the current state and the latched walk results.
    always_comb begin
        miss_ready    = (state_q == ST_IDLE);
        rd_req_valid  = (state_q == ST_ROOT_REQ) || (state_q == ST_LEAF_REQ);
        rd_req_addr   = next_addr;
        refill_valid  = (state_q == ST_REFILL);
        fault_valid   = (state_q == ST_FAULT);
        walk_vpn      = vpn_q;
        refill_ppn    = ppn_q;
        refill_perm   = perm_q;
        refill_ref    = ref_q;
        refill_mod    = mod_q;
        fault_at_leaf = leaf_fault_q;
        unused_vaddr  = ^miss_vaddr[PAGE_SHIFT-1:0];
    end

    assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(refill_valid && fault_valid));
    assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |=> !rd_req_valid);
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ready |-> (!rd_req_valid && !refill_valid && !fault_valid));
    assert_accept_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready) |=> rd_req_valid);
    assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid || fault_valid) |=> miss_ready);
    assert_refill_after_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refill_valid) |-> $past(rd_resp_valid));
    assert_busy_holds_vpn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_ready && !$past(miss_ready)) |-> $stable(walk_vpn));
endmodule

// File: tb/ptw_engine_tb.sv
// Bench: plays the memory, walks several address patterns and compares all
// outputs on every falling edge against a behavioural expectation.
module ptw_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [31:0] ROOT = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [31:0] miss_vaddr = '0;
    logic [31:0] root_base = ROOT;
    logic        rd_req_valid;
    logic [31:0] rd_req_addr;
    logic        rd_resp_valid = 1'b0;
    logic [31:0] rd_resp_data = 32'hDEAD_BEEF;
    logic        refill_valid;
    logic [19:0] walk_vpn;
    logic [19:0] refill_ppn;
    logic [2:0]  refill_perm;
    logic        refill_ref;
    logic        refill_mod;
    logic        fault_valid;
    logic        fault_at_leaf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [31:0] mem [logic [31:0]];

    ptw_engine dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: act %0d exp below %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act %h exp %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Idle-or-waiting cycle: nothing pulses.
    task automatic chk_quiet(input string tag, input logic exp_ready);
        chk({tag, " ready"}, {31'b0, miss_ready}, {31'b0, exp_ready});
        chk({tag, " req"}, {31'b0, rd_req_valid}, 32'h0);
        chk({tag, " refill"}, {31'b0, refill_valid}, 32'h0);
        chk({tag, " fault"}, {31'b0, fault_valid}, 32'h0);
    endtask

    // Serve one read with the given latency; optionally poke a busy miss.
    task automatic serve(input int lat, input bit poke, input logic [31:0] addr);
        for (int k = 0; k < lat; k++) begin
            chk_quiet("R8 wait", 1'b0);
            if (poke) begin
                miss_valid = 1'b1;
                miss_vaddr = 32'h7777_7000;
                chk("R2 busy not ready", {31'b0, miss_ready}, 32'h0);
            end
            tick();
        end
        miss_valid    = 1'b0;
        chk_quiet("R8 respond", 1'b0);
        rd_resp_valid = 1'b1;
        rd_resp_data  = mem_rd(addr);
        tick();
        rd_resp_valid = 1'b0;
        rd_resp_data  = 32'hDEAD_BEEF;
    endtask

    task automatic walk(input logic [31:0] va, input int lat, input bit poke);
        logic [19:0] vpn;
        logic [31:0] raddr, rpte, laddr, lpte;
        vpn   = va[31:12];
        raddr = ROOT + {20'b0, vpn[19:10], 2'b00};
        rpte  = mem_rd(raddr);
        laddr = {rpte[31:12], 12'h000} + {20'b0, vpn[9:0], 2'b00};
        lpte  = mem_rd(laddr);

        chk("R2 ready before", {31'b0, miss_ready}, 32'h1);
        miss_valid = 1'b1;
        miss_vaddr = va;
        tick();
        miss_valid = 1'b0;
        miss_vaddr = 32'h0;
        chk("R3 root req", {31'b0, rd_req_valid}, 32'h1);
        chk("R3 root addr", rd_req_addr, raddr);
        chk("R2 busy", {31'b0, miss_ready}, 32'h0);
        tick();
        serve(lat, poke, raddr);
        if (!rpte[0]) begin
            chk("R4 fault", {31'b0, fault_valid}, 32'h1);
            chk("R4 no leaf req", {31'b0, rd_req_valid}, 32'h0);
            chk("R4 level", {31'b0, fault_at_leaf}, 32'h0);
            chk("R4 vpn", {12'b0, walk_vpn}, {12'b0, vpn});
            chk("R10 no refill", {31'b0, refill_valid}, 32'h0);
        end else begin
            chk("R5 leaf req", {31'b0, rd_req_valid}, 32'h1);
            chk("R5 leaf addr", rd_req_addr, laddr);
            tick();
            serve(lat, poke, laddr);
            if (!lpte[0]) begin
                chk("R6 fault", {31'b0, fault_valid}, 32'h1);
                chk("R6 level", {31'b0, fault_at_leaf}, 32'h1);
                chk("R10 no refill", {31'b0, refill_valid}, 32'h0);
            end else begin
                chk("R7 refill", {31'b0, refill_valid}, 32'h1);
                chk("R7 vpn", {12'b0, walk_vpn}, {12'b0, vpn});
                chk("R7 ppn", {12'b0, refill_ppn}, {12'b0, lpte[31:12]});
                chk("R7 perm", {29'b0, refill_perm}, {29'b0, lpte[3:1]});
                chk("R7 ref", {31'b0, refill_ref}, {31'b0, lpte[5]});
                chk("R7 mod", {31'b0, refill_mod}, {31'b0, lpte[6]});
                chk("R10 no fault", {31'b0, fault_valid}, 32'h0);
            end
        end
        tick();
        chk_quiet("R9 back to idle", 1'b1);
    endtask

    initial begin
        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0002_000C] = 32'h1234_5067;
        mem[32'h0001_0FFC] = 32'h0003_0001;
        mem[32'h0003_0FFC] = 32'h0ABC_D00B;
        mem[32'h0002_0010] = 32'h9999_9FFE;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk_quiet("R1 reset", 1'b1);

        walk(32'h0040_3ABC, 0, 1'b0);
        walk(32'hFFFF_F123, 3, 1'b1);
        walk(32'h0080_0000, 2, 1'b0);
        walk(32'h0040_4000, 1, 1'b1);

        // R8: stray responses while idle change nothing.
        for (int k = 0; k < 3; k++) begin
            rd_resp_valid = 1'b1;
            rd_resp_data  = 32'hFFFF_FFFF;
            tick();
            chk_quiet("R8 stray resp", 1'b1);
        end
        rd_resp_valid = 1'b0;
        walk(32'h0040_3000, 5, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule